// File: doc/BRIEF.md
# Two-Source Interrupt Status Unit

This block collects event pulses from a timer core for two sources, an overflow event and a delay event. For each source it keeps a sticky raw status bit, an interrupt enable bit and a wake-up enable bit. From these it drives one level-sensitive interrupt line and one wake-up request line. Software sees the state through five register views. The first is a raw view, where a write of 1 sets a bit so that software can inject an event for debug. The second is a masked view, where a write of 1 clears the pending bit. The third and fourth are a pair of enable views: one sets enables on a write of 1, the other clears them on a write of 1, and both read back the same enable vector. The fifth is a plain wake-enable view.

The register decoder sits outside the block. Each view has its own write strobe and a shared write data bus. Each view has its own read data output, zero-extended to the bus width. Both outputs are registered, so each one follows the state that drives it by one clock.

Top module: `intc_evt_status`

## Requirements
- R1: A pulse on `evt_i[k]` sets raw status bit k at the next clock edge, whatever the state of enable bit k.
- R2: A raw-view write (`raw_set_we`) with a 1 in data bit k sets raw bit k. Data bits that are 0 leave their raw bits unchanged.
- R3: `masked_rd` bit k reads 1 exactly when raw bit k and enable bit k are both set.
- R4: A masked-view write (`masked_clr_we`) with a 1 in data bit k clears raw bit k, even when enable bit k is 0. Data bits that are 0 leave their raw bits unchanged.
- R5: A 1 in data bit k sets enable bit k on an `en_set_we` write and clears it on an `en_clr_we` write. Data bits that are 0 do nothing. `en_set_rd` and `en_clr_rd` both return the current enable vector. If both strobes carry a 1 for the same bit in one cycle, the bit ends up set.
- R6: In every view, bit 0 is the overflow source and bit 1 is the delay source. All bits from 2 up read as 0, even after writes of all ones.
- R7: `irq_o` equals the OR of the masked status bits as they stood one clock earlier.
- R8: If an event pulse and a masked-view clear hit the same bit in the same clock, the bit stays set. A raw-view set in the same clock as a clear of the same bit also leaves the bit set.
- R9: A `wake_we` write loads wake-enable bits 1:0 from the write data, and `wake_rd` returns them.
- R10: `wake_o` equals the OR of (raw bit AND wake-enable bit) over both sources, as they stood one clock earlier.
- R11: After reset, all status, enable and wake-enable bits are 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 2 | Event pulses from the timer core (bit 0 overflow, bit 1 delay) |
| raw_set_we | input | 1 | Write strobe for the raw view (1 sets the bit) |
| masked_clr_we | input | 1 | Write strobe for the masked view (1 clears the bit) |
| en_set_we | input | 1 | Write strobe for the enable-set view |
| en_clr_we | input | 1 | Write strobe for the enable-clear view |
| wake_we | input | 1 | Write strobe for the wake-enable view |
| wr_data | input | DATA_W | Shared write data |
| raw_rd | output | DATA_W | Raw status read data |
| masked_rd | output | DATA_W | Masked status read data |
| en_set_rd | output | DATA_W | Enable vector, read through the set view |
| en_clr_rd | output | DATA_W | Enable vector, read through the clear view |
| wake_rd | output | DATA_W | Wake-enable read data |
| irq_o | output | 1 | Level interrupt, registered |
| wake_o | output | 1 | Wake-up request, registered |

## Verification
The bench builds the block with the default DATA_W of 32. At that width, writes of all ones can reach the upper data bits, so the bench can confirm that bits 31:2 stay zero in every read view. The source count is fixed at two, which makes it practical to step through every combination of event, set and clear on both bits. This includes the same-cycle conflicts, where hardware events and set strobes must beat clears.

// File: rtl/intc_evt_pkg.sv
package intc_evt_pkg;
    localparam int EVT_N   = 2;
    localparam int OVF_BIT = 0;
    localparam int DLY_BIT = 1;

    typedef logic [EVT_N-1:0] evt_vec_t;

    typedef struct packed {
        evt_vec_t raw;
    } raw_state_t;

    typedef struct packed {
        evt_vec_t en;
        evt_vec_t wk;
    } en_state_t;

    typedef struct packed {
        logic irq;
        logic wake;
    } out_state_t;
endpackage

// File: rtl/intc_raw_bank.sv
module intc_raw_bank
    import intc_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t evt_i,
    input  evt_vec_t set_i,
    input  evt_vec_t clr_i,
    output evt_vec_t raw_o
);
    raw_state_t st_d, st_q;
    evt_vec_t   bit_nxt;

    // Per source: event and set beat clear
    for (genvar k = 0; k < EVT_N; k++) begin : g_bit
        assign bit_nxt[k] = evt_i[k] | set_i[k] | (st_q.raw[k] & ~clr_i[k]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.raw = bit_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;
endmodule

// File: rtl/intc_en_bank.sv
module intc_en_bank
    import intc_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t en_set_i,
    input  evt_vec_t en_clr_i,
    input  logic     wk_we_i,
    input  evt_vec_t wk_data_i,
    output evt_vec_t en_o,
    output evt_vec_t wk_o
);
    en_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = (st_q.en & ~en_clr_i) | en_set_i;
        if (wk_we_i) st_d.wk = wk_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;
    assign wk_o = st_q.wk;
endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage
    import intc_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t raw_i,
    input  evt_vec_t en_i,
    input  evt_vec_t wk_i,
    output logic     irq_o,
    output logic     wake_o
);
    out_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.irq  = |(raw_i & en_i);
        st_d.wake = |(raw_i & wk_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o  = st_q.irq;
    assign wake_o = st_q.wake;
endmodule

// File: rtl/intc_evt_status.sv
module intc_evt_status
    import intc_evt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        evt_i,
    input  logic              raw_set_we,
    input  logic              masked_clr_we,
    input  logic              en_set_we,
    input  logic              en_clr_we,
    input  logic              wake_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] raw_rd,
    output logic [DATA_W-1:0] masked_rd,
    output logic [DATA_W-1:0] en_set_rd,
    output logic [DATA_W-1:0] en_clr_rd,
    output logic [DATA_W-1:0] wake_rd,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int PAD_W = DATA_W - EVT_N;

    evt_vec_t wd, raw_v, en_v, wk_v;
    evt_vec_t raw_set_v, raw_clr_v, en_set_v, en_clr_v;

    assign wd        = wr_data[EVT_N-1:0];
    assign raw_set_v = raw_set_we    ? wd : '0;
    assign raw_clr_v = masked_clr_we ? wd : '0;
    assign en_set_v  = en_set_we     ? wd : '0;
    assign en_clr_v  = en_clr_we     ? wd : '0;

    intc_raw_bank u_raw (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .set_i (raw_set_v),
        .clr_i (raw_clr_v),
        .raw_o (raw_v)
    );

    intc_en_bank u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set_i  (en_set_v),
        .en_clr_i  (en_clr_v),
        .wk_we_i   (wake_we),
        .wk_data_i (wd),
        .en_o      (en_v),
        .wk_o      (wk_v)
    );

    intc_out_stage u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_v),
        .en_i   (en_v),
        .wk_i   (wk_v),
        .irq_o  (irq_o),
        .wake_o (wake_o)
    );

    assign raw_rd    = {{PAD_W{1'b0}}, raw_v};
    assign masked_rd = {{PAD_W{1'b0}}, raw_v & en_v};
    assign en_set_rd = {{PAD_W{1'b0}}, en_v};
    assign en_clr_rd = {{PAD_W{1'b0}}, en_v};
    assign wake_rd   = {{PAD_W{1'b0}}, wk_v};
endmodule

// File: rtl/intc_evt_status_chk.sv
module intc_evt_status_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        evt_i,
    input logic              raw_set_we,
    input logic              masked_clr_we,
    input logic              en_set_we,
    input logic              en_clr_we,
    input logic              wake_we,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] raw_rd,
    input logic [DATA_W-1:0] masked_rd,
    input logic [DATA_W-1:0] en_set_rd,
    input logic [DATA_W-1:0] en_clr_rd,
    input logic [DATA_W-1:0] wake_rd,
    input logic              irq_o,
    input logic              wake_o
);
    AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((raw_rd[1:0] & $past(evt_i)) == $past(evt_i)));   // R1
    AST_CLR_DROPS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_clr_we && !raw_set_we) |=>
        ((raw_rd[1:0] & $past(wr_data[1:0]) & ~$past(evt_i)) == 2'b00)); // R4
    AST_ENSET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        en_set_we |=> ((en_clr_rd[1:0] & $past(wr_data[1:0])) == $past(wr_data[1:0]))); // R5
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|masked_rd)));                          // R7
    AST_WAKE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wake_o == $past(|(raw_rd & wake_rd))));                // R10
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|evt_i) && !raw_set_we && !masked_clr_we) |=> $stable(raw_rd)); // R2
endmodule

bind intc_evt_status intc_evt_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/intc_evt_status_test.sv
module intc_evt_status_test;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    evt_i = '0;
    logic          raw_set_we = 1'b0, masked_clr_we = 1'b0;
    logic          en_set_we = 1'b0, en_clr_we = 1'b0, wake_we = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] raw_rd, masked_rd, en_set_rd, en_clr_rd, wake_rd;
    logic          irq_o, wake_o;

    always #4 clk = ~clk;   // 125 MHz

    intc_evt_status #(.DATA_W(DW)) uut (.*);

    typedef struct {
        logic [DW-1:0] raw, msk, ens, enc, wk;
        logic          irq, wake;
        string         req;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_raw = '0, m_en = '0, m_wk = '0;

    task automatic step(input logic [1:0] ev, input logic rs, input logic mc,
                        input logic es, input logic ec, input logic wk,
                        input logic [DW-1:0] d, input string req);
        item_t it;
        logic  irq_n, wake_n;
        logic [1:0] dd;
        @(negedge clk);
        evt_i = ev; raw_set_we = rs; masked_clr_we = mc;
        en_set_we = es; en_clr_we = ec; wake_we = wk; wr_data = d;
        dd = d[1:0];
        irq_n  = |(m_raw & m_en);
        wake_n = |(m_raw & m_wk);
        m_raw = ev | (rs ? dd : 2'b00) | (m_raw & ~(mc ? dd : 2'b00));
        m_en  = (m_en & ~(ec ? dd : 2'b00)) | (es ? dd : 2'b00);
        if (wk) m_wk = dd;
        it.raw  = {30'd0, m_raw};
        it.msk  = {30'd0, m_raw & m_en};
        it.ens  = {30'd0, m_en};
        it.enc  = {30'd0, m_en};
        it.wk   = {30'd0, m_wk};
        it.irq  = irq_n;
        it.wake = wake_n;
        it.req  = req;
        q.push_back(it);
    endtask

    task automatic idle(input string req);
        step(2'b00, 0, 0, 0, 0, 0, '0, req);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t e;
                e = q.pop_front();
                n_chk++;
                if (raw_rd !== e.raw || masked_rd !== e.msk || en_set_rd !== e.ens ||
                    en_clr_rd !== e.enc || wake_rd !== e.wk || irq_o !== e.irq ||
                    wake_o !== e.wake) begin
                    n_bad++;
                    $display("FAIL %s: act raw=%h msk=%h ens=%h enc=%h wk=%h irq=%b wake=%b exp raw=%h msk=%h ens=%h enc=%h wk=%h irq=%b wake=%b",
                        e.req, raw_rd, masked_rd, en_set_rd, en_clr_rd, wake_rd, irq_o, wake_o,
                        e.raw, e.msk, e.ens, e.enc, e.wk, e.irq, e.wake);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        n_chk++;
        if (raw_rd !== '0 || masked_rd !== '0 || en_set_rd !== '0 || en_clr_rd !== '0 ||
            wake_rd !== '0 || irq_o !== 1'b0 || wake_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R11: act raw=%h en=%h wk=%h irq=%b wake=%b exp all zero",
                     raw_rd, en_set_rd, wake_rd, irq_o, wake_o);
        end
        rst_n = 1'b1;
        idle("R11 idle after reset");

        // R1: overflow event while disabled; no interrupt
        step(2'b01, 0, 0, 0, 0, 0, '0, "R1 ovf event disabled");
        idle("R7 irq stays low while disabled");
        // R5/R3: enable overflow, masked appears, irq a cycle later (R7)
        step(2'b00, 0, 0, 1, 0, 0, 32'h1, "R5 enable ovf");
        idle("R3 masked follows enable / R7 irq rises");
        idle("R7 irq held");
        // R4: clear through masked view
        step(2'b00, 0, 1, 0, 0, 0, 32'h1, "R4 clear ovf");
        idle("R7 irq falls");
        // R2: debug set of delay bit; write 0 does nothing
        step(2'b00, 1, 0, 0, 0, 0, 32'h2, "R2 set dly by write");
        step(2'b00, 1, 0, 0, 0, 0, 32'h0, "R2 zero write no effect");
        // R4: masked write 0 no effect; clear disabled dly bit
        step(2'b00, 0, 1, 0, 0, 0, 32'h0, "R4 zero clear no effect");
        step(2'b00, 0, 1, 0, 0, 0, 32'h2, "R4 clear while disabled");
        idle("R4 settle");
        // R8: event and clear same cycle
        step(2'b10, 0, 1, 0, 0, 0, 32'h2, "R8 event beats clear");
        step(2'b00, 1, 1, 0, 0, 0, 32'h1, "R8 set beats clear");
        // R5: set and clear same cycle, zeros ignored, disable
        step(2'b00, 0, 0, 1, 1, 0, 32'h2, "R5 set beats clear");
        step(2'b00, 0, 0, 0, 1, 0, 32'h0, "R5 zero disable no effect");
        step(2'b00, 0, 0, 1, 0, 0, 32'h0, "R5 zero enable no effect");
        idle("R3 both pending one enabled");
        step(2'b00, 0, 0, 0, 1, 0, 32'h3, "R5 disable all");
        idle("R7 irq low after disable");
        // R9/R10: wake enables
        step(2'b00, 0, 0, 0, 0, 1, 32'h1, "R9 wake ovf only");
        idle("R10 wake from ovf");
        step(2'b00, 0, 1, 0, 0, 0, 32'h1, "R10 clear ovf");
        idle("R10 wake drops");
        step(2'b00, 0, 0, 0, 0, 1, 32'h2, "R9 wake dly only");
        idle("R10 wake from dly");
        // R6: all-ones writes, upper bits zero, bit order
        step(2'b00, 1, 0, 1, 0, 1, 32'hFFFF_FFFF, "R6 all ones");
        idle("R6 upper bits zero");
        step(2'b00, 0, 1, 0, 0, 0, 32'hFFFF_FFFF, "R6 clear all");
        step(2'b01, 0, 0, 0, 0, 0, '0, "R6 ovf at bit0");
        step(2'b10, 0, 0, 0, 0, 0, '0, "R6 dly at bit1");
        step(2'b11, 0, 1, 0, 0, 0, 32'h3, "R8 both events beat clear");
        idle("R7 irq from both");
        idle("R10 final");
        idle("drain");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule